// File: doc/BRIEF.md
# Automatic UART Hardware Flow Control

This block adds automatic hardware handshaking to a UART in both directions.

On the receive side it compares the fill count of the receive FIFO with a trigger threshold. Software picks that threshold from a fixed four-entry table. The block raises a trigger interrupt when the threshold is reached. It also drives the active-low request-to-send line with hysteresis, using the table entries on either side of the selected one. RTS is withdrawn at the next entry above the selected one and granted again once the count drops below the next entry below it.

On the transmit side it passes the active-low clear-to-send line through a synchroniser. It then holds back the start of each new character while the far end withdraws CTS. A character the serialiser is already sending always runs to its end.

Each direction has its own enable. With automatic RTS disabled, the RTS pin simply mirrors a software request bit. The FIFO is represented here only by its fill count, and the serialiser only by a request/busy/start handshake.

Top module: `uart_hwflow`

## Requirements
- R1: While reset is held and after it is released, `trig_irq` is 0. The internal stop state is cleared, so `rts_n` equals the inverse of `rts_req`. The CTS synchroniser resets to the deasserted (high) value, so with `auto_cts_en`=1 `tx_start` is 0 until a low on `cts_n` has passed through.
- R2: The trigger table, indexed by `trig_sel`, is 0:1, 1:DEPTH/4, 2:DEPTH/2 and 3:DEPTH-2 entries. With the default depth of 16 this gives 1, 4, 8 and 14. With `auto_rts_en`=1, `trig_irq` is 1 in the cycle after the clock edge at which `rx_level` is at or above the selected entry, and 0 otherwise.
- R3: With `auto_rts_en`=1 and `rts_req`=1, `rts_n` goes high after the clock edge at which `rx_level` is at or above the upper threshold. The upper threshold is the next table entry above the selected one, or DEPTH (full) for `trig_sel`=3. For depth 16 the upper thresholds are 4, 8, 14 and 16.
- R4: Under the same conditions, `rts_n` returns low after the clock edge at which `rx_level` is below the next table entry below the selected one. For `trig_sel`=0, that point is an empty FIFO. For depth 16 the release is at counts at or under 0, 0, 3 and 7.
- R5: While `rx_level` lies strictly between the release and upper thresholds, `rts_n` keeps its previous value (hysteresis).
- R6: Automatic RTS acts only while software asserts `rts_req`=1. With `rts_req`=0, `rts_n` is 1 at every fill level.
- R7: With `auto_rts_en`=0, `rts_n` equals the inverse of `rts_req` and `trig_irq` is 0 for every fill level.
- R8: With `auto_cts_en`=1, a change on `cts_n` affects `tx_start` two clock edges later. While the synchronised CTS is high, `tx_start` is 0. Once CTS is low again, starts resume.
- R9: `tx_start` is 1 only when `tx_req`=1 and `tx_busy`=0. A pause never interrupts a character in progress.
- R10: With `auto_cts_en`=0, `cts_n` has no effect and `tx_start` equals `tx_req` AND NOT `tx_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| auto_cts_en | input | 1 | Enable automatic CTS gating |
| rts_req | input | 1 | Software RTS request, 1 = assert |
| trig_sel | input | 2 | Index into the trigger-level table |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| cts_n | input | 1 | Clear-to-send from the far end, active low |
| tx_req | input | 1 | A character is waiting to be sent |
| tx_busy | input | 1 | Serialiser is shifting a character |
| rts_n | output | 1 | Request-to-send pin, active low |
| trig_irq | output | 1 | Receive trigger level reached |
| tx_start | output | 1 | Start the next character |

## Verification
A stop state that sets or clears at the wrong fill count appears on `rts_n` one clock after the offending count. Sweeping the count up to full and back down to empty, for every table entry, exposes any wrong neighbour threshold or missing hysteresis. An interrupt compare on the wrong entry shows on `trig_irq` within the same single-cycle latency. A synchroniser with the wrong depth or reset value moves or mis-sets the edge at which `tx_start` follows a CTS change, which shows within two cycles.

// File: rtl/uart_hwflow_pkg.sv
package uart_hwflow_pkg;

  // Fill count at which the trigger interrupt fires, per table index.
  function automatic int unsigned trig_level(input int unsigned depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Fill count at which RTS is withdrawn: next entry up, full for the top entry.
  function automatic int unsigned halt_level(input int unsigned depth, input logic [1:0] sel);
    if (sel == 2'd3) return depth;
    return trig_level(depth, sel + 2'd1);
  endfunction

  // Highest fill count at which RTS is granted again: below the next entry down.
  function automatic int unsigned release_level(input int unsigned depth, input logic [1:0] sel);
    if (sel == 2'd0) return 0;
    return trig_level(depth, sel - 2'd1) - 1;
  endfunction

endpackage

// File: rtl/hwflow_cts_sync.sv
module hwflow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b1;   // deasserted CTS until proven otherwise
        else if (i == 0) stage_q[i] <= d_in;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/hwflow_rx_rts.sv
module hwflow_rx_rts
  import uart_hwflow_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          req,
  input  logic [1:0]    sel,
  input  logic [LW-1:0] level,
  output logic          rts_n,
  output logic          irq
);
  logic [LW-1:0] trig_lvl, halt_lvl, rel_lvl;
  logic          hit_upper, hit_lower, hit_trig;
  logic          halted_q, irq_q, aged_q;

  assign trig_lvl  = LW'(trig_level(DEPTH, sel));
  assign halt_lvl  = LW'(halt_level(DEPTH, sel));
  assign rel_lvl   = LW'(release_level(DEPTH, sel));

  assign hit_upper = level >= halt_lvl;
  assign hit_lower = level <= rel_lvl;
  assign hit_trig  = level >= trig_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      irq_q    <= 1'b0;
      aged_q   <= 1'b0;
    end else begin
      aged_q <= 1'b1;
      irq_q  <= auto_en & hit_trig;
      if (!auto_en)       halted_q <= 1'b0;
      else if (hit_upper) halted_q <= 1'b1;
      else if (hit_lower) halted_q <= 1'b0;
    end
  end

  // Software must request RTS before the automatic stop has any say.
  assign rts_n = ~req | (auto_en & halted_q);
  assign irq   = irq_q;

  a_r2_irq_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && $past(auto_en && hit_trig)) |-> irq);
  a_r7_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && !$past(auto_en)) |-> !irq);
  a_r3_stop_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && $past(auto_en && hit_upper) && auto_en && req) |-> rts_n);
  a_r4_go_at_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && $past(hit_lower) && req) |-> !rts_n);
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && $past(auto_en) && $past(!hit_upper && !hit_lower)) |-> halted_q == $past(halted_q));
  a_r6_no_req_high: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> rts_n);
endmodule

// File: rtl/hwflow_tx_gate.sv
module hwflow_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_sync_n,
  input  logic tx_req,
  input  logic tx_busy,
  output logic tx_start
);
  logic paused;

  assign paused   = auto_en & cts_sync_n;
  assign tx_start = tx_req & ~tx_busy & ~paused;

  a_r9_never_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_start);
  a_r9_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |-> !tx_start);
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow
  import uart_hwflow_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          rts_req,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          cts_n,
  input  logic          tx_req,
  input  logic          tx_busy,
  output logic          rts_n,
  output logic          trig_irq,
  output logic          tx_start
);
  logic       cts_sync_n;
  logic [1:0] age_q;

  hwflow_rx_rts #(.DEPTH(DEPTH), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .req(rts_req),
    .sel(trig_sel), .level(rx_level), .rts_n(rts_n), .irq(trig_irq)
  );

  hwflow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(cts_n), .d_out(cts_sync_n)
  );

  hwflow_tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_sync_n(cts_sync_n),
    .tx_req(tx_req), .tx_busy(tx_busy), .tx_start(tx_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // With two stages, the pin value two edges back is what gates starts now.
  a_r8_cts_pauses: assert property (@(posedge clk) disable iff (!rst_n)
    (SYNC_STAGES == 2 && age_q == 2'd2 && auto_cts_en && $past(cts_n, 2)) |-> !tx_start);
  a_r10_cts_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts_en && tx_req && !tx_busy) |-> tx_start);
endmodule

// File: tb/uart_hwflow_test.sv
`timescale 1ns/1ps
module uart_hwflow_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_rts_en, auto_cts_en, rts_req;
  logic [1:0] trig_sel;
  logic [4:0] rx_level;
  logic       cts_n, tx_req, tx_busy;
  logic       rts_n, trig_irq, tx_start;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  uart_hwflow uut (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rts_req(rts_req), .trig_sel(trig_sel), .rx_level(rx_level), .cts_n(cts_n),
    .tx_req(tx_req), .tx_busy(tx_busy), .rts_n(rts_n), .trig_irq(trig_irq),
    .tx_start(tx_start)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tb_trig(input int s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction
  function automatic int tb_upper(input int s);
    return (s == 3) ? 16 : tb_trig(s + 1);
  endfunction
  function automatic int tb_lower(input int s);
    return (s == 0) ? 0 : tb_trig(s - 1) - 1;
  endfunction

  // Drive one fill count, then look one edge later.
  task automatic put_level(input int lv);
    @(negedge clk);
    rx_level = 5'(lv);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic exp_stop;
    rst_n = 1'b0; auto_rts_en = 1'b0; auto_cts_en = 1'b1; rts_req = 1'b0;
    trig_sel = 2'd0; rx_level = 5'd16; cts_n = 1'b0; tx_req = 1'b1; tx_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rts_n in reset", rts_n, 1'b1);
    chk("R1 irq in reset", trig_irq, 1'b0);
    chk("R1 tx_start in reset", tx_start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync still high after one edge", tx_start, 1'b0);
    @(negedge clk);
    chk("R8 start after low propagates", tx_start, 1'b1);

    // R7: automatic RTS disabled, pin follows request bit
    for (int rq = 0; rq < 2; rq++) begin
      rts_req = rq[0];
      for (int lv = 0; lv <= 16; lv += 4) begin
        put_level(lv);
        chk("R7 rts_n follows request", rts_n, ~rq[0]);
        chk("R7 irq stays low", trig_irq, 1'b0);
      end
    end

    // R2..R5: full ramp up and down for every table entry
    auto_rts_en = 1'b1; rts_req = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); trig_sel = 2'(s); rx_level = 5'd0;
      @(negedge clk);
      exp_stop = 1'b0;
      for (int step = 0; step <= 32; step++) begin
        int lv;
        lv = (step <= 16) ? step : 32 - step;
        put_level(lv);
        if (lv >= tb_upper(s)) exp_stop = 1'b1;
        else if (lv <= tb_lower(s)) exp_stop = 1'b0;
        chk("R2 irq vs trigger table", trig_irq, (lv >= tb_trig(s)));
        if (lv >= tb_upper(s)) chk("R3 stop at upper", rts_n, exp_stop);
        else if (lv <= tb_lower(s)) chk("R4 go at lower", rts_n, exp_stop);
        else chk("R5 hysteresis hold", rts_n, exp_stop);
      end
    end

    // R6: request bit low forces rts_n high at every level
    trig_sel = 2'd1;
    rts_req = 1'b0;
    for (int lv = 0; lv <= 16; lv++) begin
      put_level(lv);
      chk("R6 no request keeps rts_n high", rts_n, 1'b1);
    end
    put_level(0);
    rts_req = 1'b1;
    #1 chk("R6 request grants when not stopped", rts_n, 1'b0);

    // R8: CTS latency and pause
    @(negedge clk); auto_cts_en = 1'b1; tx_req = 1'b1; tx_busy = 1'b0; cts_n = 1'b1;
    @(negedge clk);
    chk("R8 one edge after CTS high still starts", tx_start, 1'b1);
    @(negedge clk);
    chk("R8 paused after two edges", tx_start, 1'b0);
    cts_n = 1'b0;
    @(negedge clk);
    chk("R8 still paused after one edge", tx_start, 1'b0);
    @(negedge clk);
    chk("R8 resumes after two edges", tx_start, 1'b1);

    // R9/R10: exhaustive gating over settled inputs
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      tx_req = v[0]; tx_busy = v[1]; auto_cts_en = v[2]; cts_n = v[3];
      @(negedge clk); @(negedge clk);
      if (!v[2]) chk("R10 CTS ignored when off", tx_start, v[0] & ~v[1]);
      else chk("R9 start gating", tx_start, v[0] & ~v[1] & ~v[3]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule